// File: doc/BRIEF.md
# CRC request interval generator

This block paces checksum requests for a target device that moves data over a parallel storage bus in double-transition data phases. It counts the bytes that move in target mode and, once the count reaches an interval chosen by a 4-bit code, emits a one-cycle CRC request so the checksum can be exchanged. Software or a sequencer may also force a request. A request-acceptable flag stops a second request before any new data byte has moved.

A protocol monitor watches the bus phase. If the phase leaves a double-transition data phase while data has moved since the last request, it raises a one-cycle protocol error. A separate output reports CRC mismatches from the checksum unit. Each of the two checks has its own disable input. The interval table is `2**BASE_LOG2` bytes for code 1, and the size doubles at each code up to code 10. With the default of 7, the table runs from 128 bytes to 65536 bytes.

Control state machine: `ST_ARMED` (a request is acceptable) and `ST_PENDING` (a request has been sent and no byte has moved since). ARMED goes to PENDING on any request. PENDING goes to ARMED on a byte strobe that does not itself produce a request. In every other case the state stays as it is. Reset enters ARMED.

Top module: `crc_req_gen`

## Requirements
- R1: For interval code k with 1 <= k <= 10, the interval is N = 2**(BASE_LOG2+k-1) bytes. `crc_req` goes high for one cycle in the cycle after the edge that samples the N-th counted byte strobe, and counting then restarts from zero.
- R2: Codes 0 and 11 to 15 produce no automatic request, and byte strobes under these codes do not advance the counter.
- R3: The block is active only when `target_mode` is 1 and `bus_phase` is 3'b000 (DT data-out) or 3'b001 (DT data-in). Outside these conditions no request of either kind is issued.
- R4: When `cnt_clear` is high at an edge, the byte counter becomes zero, and the next automatic request needs a full interval of new bytes.
- R5: `req_ok` goes low in the same cycle that `crc_req` is high. It stays low until a byte strobe moves with no new request, and it is high again in the following cycle.
- R6: `force_req` issues a request only when `req_ok` is high and the block is active. A forced request clears the byte counter. Two requests never appear in consecutive cycles.
- R7: When `proto_chk_off` is 0 and `target_mode` is 1, a change of `bus_phase` away from a DT data phase while `req_ok` is high gives a one-cycle `proto_err` pulse in the following cycle. When `proto_chk_off` is 1, `proto_err` stays low.
- R8: `crc_err` repeats `crc_mismatch` one cycle later while `crc_chk_off` is 0, and it is held low while `crc_chk_off` is 1.
- R9: While the block is not active, the byte counter holds its value unless `cnt_clear` is high, and counting continues from that value when the block is active again.
- R10: After reset, `crc_req`, `proto_err` and `crc_err` are low, `req_ok` is high and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ivl_code | input | 4 | Interval code (0 and 11 to 15 disable automatic requests) |
| cnt_clear | input | 1 | Clears the byte counter |
| target_mode | input | 1 | 1 = target, 0 = initiator |
| bus_phase | input | 3 | Bus phase: 0 = DT data-out, 1 = DT data-in, other values = non-DT phases |
| byte_stb | input | 1 | One data byte transferred this cycle |
| force_req | input | 1 | Request for an immediate CRC request |
| crc_mismatch | input | 1 | Raw CRC mismatch from the checksum unit |
| crc_chk_off | input | 1 | Disables CRC error reporting |
| proto_chk_off | input | 1 | Disables the phase-change protocol check |
| crc_req | output | 1 | One-cycle CRC request pulse |
| req_ok | output | 1 | A CRC request is acceptable |
| proto_err | output | 1 | One-cycle phase-change protocol error |
| crc_err | output | 1 | Reported CRC error |

## Verification
The bench builds the block with BASE_LOG2 = 2. Code 1 then means 4 bytes, code 2 means 8 bytes and code 10 means 2048 bytes, so every entry in the table, including the longest one, can be reached in a short run. The small intervals let the bench mix several forced requests, a forced request on the same cycle as a byte, holds outside the active window, counter clears and phase changes within a few dozen cycles. With these settings an early or late pulse caused by a counter fault shows up at once.

// File: rtl/crc_req_pkg.sv
package crc_req_pkg;

    localparam logic [2:0] PH_DT_OUT = 3'b000;
    localparam logic [2:0] PH_DT_IN  = 3'b001;
    localparam logic [2:0] PH_IDLE   = 3'b111;
    localparam int         CODE_MAX  = 10;

    typedef enum logic [0:0] {
        ST_ARMED   = 1'b0,
        ST_PENDING = 1'b1
    } req_state_e;

    function automatic logic is_dt(input logic [2:0] ph);
        return (ph == PH_DT_OUT) || (ph == PH_DT_IN);
    endfunction

    // Byte count for a code; zero means automatic requests are off.
    function automatic logic [31:0] ivl_bytes(input logic [3:0] code, input int base);
        if (code >= 4'd1 && int'(code) <= CODE_MAX)
            return 32'd1 << (base + int'(code) - 1);
        return 32'd0;
    endfunction

endpackage

// File: rtl/crc_ivl_counter.sv
module crc_ivl_counter #(
    parameter int BASE_LOG2 = 7,
    parameter int CNT_W     = BASE_LOG2 + 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       code,
    input  logic             clr,
    input  logic             adv,
    input  logic             restart,
    output logic             hit,
    output logic [CNT_W-1:0] cnt_val
);
    logic [31:0] ivl;
    logic [31:0] inc;
    logic        en;

    always_comb begin
        ivl = crc_req_pkg::ivl_bytes(code, BASE_LOG2);
        en  = (ivl != 32'd0);
        inc = 32'(cnt_val) + 32'd1;
        hit = adv && en && (inc >= ivl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_val <= '0;
        else if (clr || hit || restart)
            cnt_val <= '0;
        else if (adv && en)
            cnt_val <= cnt_val + 1'b1;
    end
endmodule

// File: rtl/crc_req_fsm.sv
module crc_req_fsm
    import crc_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic force_req,
    input  logic active,
    input  logic byte_stb,
    output logic force_ok,
    output logic crc_req,
    output logic req_ok,
    output logic pending
);
    req_state_e state, state_nxt;
    logic       fire;

    always_comb begin
        force_ok  = force_req && active && (state == ST_ARMED);
        fire      = hit || force_ok;
        state_nxt = state;
        unique case (state)
            ST_ARMED:   if (fire) state_nxt = ST_PENDING;
            ST_PENDING: if (!fire && byte_stb) state_nxt = ST_ARMED;
            default:    state_nxt = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_ARMED;
            crc_req <= 1'b0;
        end else begin
            state   <= state_nxt;
            crc_req <= fire;
        end
    end

    always_comb begin
        req_ok  = (state == ST_ARMED);
        pending = (state == ST_PENDING);
    end
endmodule

// File: rtl/crc_proto_mon.sv
module crc_proto_mon
    import crc_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       target_mode,
    input  logic [2:0] bus_phase,
    input  logic       pending,
    input  logic       crc_mismatch,
    input  logic       crc_chk_off,
    input  logic       proto_chk_off,
    output logic       proto_err,
    output logic       crc_err
);
    logic [2:0] prev_phase;
    logic       bad_change;

    always_comb
        bad_change = target_mode && is_dt(prev_phase) && (bus_phase != prev_phase)
                     && !pending && !proto_chk_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_phase <= PH_IDLE;
            proto_err  <= 1'b0;
            crc_err    <= 1'b0;
        end else begin
            prev_phase <= bus_phase;
            proto_err  <= bad_change;
            crc_err    <= crc_mismatch && !crc_chk_off;
        end
    end
endmodule

// File: rtl/crc_req_gen.sv
module crc_req_gen #(
    parameter int BASE_LOG2 = 7,
    localparam int CNT_W    = BASE_LOG2 + 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ivl_code,
    input  logic       cnt_clear,
    input  logic       target_mode,
    input  logic [2:0] bus_phase,
    input  logic       byte_stb,
    input  logic       force_req,
    input  logic       crc_mismatch,
    input  logic       crc_chk_off,
    input  logic       proto_chk_off,
    output logic       crc_req,
    output logic       req_ok,
    output logic       proto_err,
    output logic       crc_err
);
    logic             active;
    logic             hit;
    logic             force_ok;
    logic             pending;
    logic [CNT_W-1:0] cnt_val;

    always_comb active = target_mode && crc_req_pkg::is_dt(bus_phase);

    crc_ivl_counter #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (ivl_code),
        .clr     (cnt_clear),
        .adv     (active && byte_stb),
        .restart (force_ok),
        .hit     (hit),
        .cnt_val (cnt_val)
    );

    crc_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .force_req (force_req),
        .active    (active),
        .byte_stb  (byte_stb),
        .force_ok  (force_ok),
        .crc_req   (crc_req),
        .req_ok    (req_ok),
        .pending   (pending)
    );

    crc_proto_mon u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .target_mode   (target_mode),
        .bus_phase     (bus_phase),
        .pending       (pending),
        .crc_mismatch  (crc_mismatch),
        .crc_chk_off   (crc_chk_off),
        .proto_chk_off (proto_chk_off),
        .proto_err     (proto_err),
        .crc_err       (crc_err)
    );
endmodule

// File: rtl/crc_req_chk.sv
module crc_req_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       ivl_code,
    input logic             cnt_clear,
    input logic             target_mode,
    input logic [2:0]       bus_phase,
    input logic             byte_stb,
    input logic             force_req,
    input logic             crc_chk_off,
    input logic             proto_chk_off,
    input logic             crc_req,
    input logic             req_ok,
    input logic             proto_err,
    input logic             crc_err,
    input logic [CNT_W-1:0] cnt_val
);
    logic in_window;
    logic code_off;

    always_comb begin
        in_window = target_mode && (bus_phase == 3'b000 || bus_phase == 3'b001);
        code_off  = (ivl_code == 4'd0) || (ivl_code > 4'd10);
    end

    AST_CODE_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (code_off && !force_req) |=> !crc_req);                                 // R2
    AST_OUTSIDE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |=> !crc_req);                                               // R3
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (cnt_val == '0));                                         // R4
    AST_REQ_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        crc_req |-> !req_ok);                                                   // R5
    AST_BYTE_RAISES_OK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> (req_ok || crc_req));                                      // R5
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        crc_req |=> !crc_req);                                                  // R6
    AST_PROTO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        proto_chk_off |=> !proto_err);                                          // R7
    AST_CRC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        crc_chk_off |=> !crc_err);                                              // R8
    AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_window && !cnt_clear) |=> $stable(cnt_val));                       // R9
endmodule

bind crc_req_gen crc_req_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ivl_code      (ivl_code),
    .cnt_clear     (cnt_clear),
    .target_mode   (target_mode),
    .bus_phase     (bus_phase),
    .byte_stb      (byte_stb),
    .force_req     (force_req),
    .crc_chk_off   (crc_chk_off),
    .proto_chk_off (proto_chk_off),
    .crc_req       (crc_req),
    .req_ok        (req_ok),
    .proto_err     (proto_err),
    .crc_err       (crc_err),
    .cnt_val       (cnt_val)
);

// File: tb/tb_crc_req_gen.sv
module tb_crc_req_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  e_req;
        logic  e_ok;
        logic  e_perr;
        logic  e_cerr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ivl_code = 4'd1;
    logic       cnt_clear = 1'b0;
    logic       target_mode = 1'b1;
    logic [2:0] bus_phase = 3'b000;
    logic       byte_stb = 1'b0;
    logic       force_req = 1'b0;
    logic       crc_mismatch = 1'b0;
    logic       crc_chk_off = 1'b0;
    logic       proto_chk_off = 1'b0;
    logic       crc_req, req_ok, proto_err, crc_err;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    crc_req_gen #(.BASE_LOG2(2)) dut (
        .clk(clk), .rst_n(rst_n), .ivl_code(ivl_code), .cnt_clear(cnt_clear),
        .target_mode(target_mode), .bus_phase(bus_phase), .byte_stb(byte_stb),
        .force_req(force_req), .crc_mismatch(crc_mismatch), .crc_chk_off(crc_chk_off),
        .proto_chk_off(proto_chk_off), .crc_req(crc_req), .req_ok(req_ok),
        .proto_err(proto_err), .crc_err(crc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops one expectation per falling edge and compares outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (crc_req !== it.e_req || req_ok !== it.e_ok ||
                    proto_err !== it.e_perr || crc_err !== it.e_cerr) begin
                    fails++;
                    $display("FAIL %s: req/ok/perr/cerr = %0b%0b%0b%0b expected %0b%0b%0b%0b",
                             it.tag, crc_req, req_ok, proto_err, crc_err,
                             it.e_req, it.e_ok, it.e_perr, it.e_cerr);
                end
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the outputs expected after it.
    task automatic step(input logic b, input logic f, input logic c,
                        input logic er, input logic eo, input logic ep, input logic ec,
                        input string tag);
        exp_t it;
        @(negedge clk);
        byte_stb  = b;
        force_req = f;
        cnt_clear = c;
        @(posedge clk);
        #1;
        it.e_req = er; it.e_ok = eo; it.e_perr = ep; it.e_cerr = ec; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 1, 0, 0, tag);
    endtask

    task automatic byte_req(input string tag);
        step(1, 0, 0, 1, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 0, 0, 1, 0, 0, "R10 reset state");

        // R1: code 1 = 4 bytes
        bytes(3, "R1 code1 before interval");
        byte_req("R1 code1 request on 4th byte");
        step(0, 0, 0, 0, 0, 0, 0, "R5 ok stays low without data");
        bytes(1, "R5 byte raises ok");
        step(0, 0, 1, 0, 1, 0, 0, "R4 clear");

        // R1: code 2 = 8 bytes
        ivl_code = 4'd2;
        bytes(7, "R1 code2 before interval");
        byte_req("R1 code2 request on 8th byte");
        step(0, 0, 1, 0, 0, 0, 0, "R4 clear while pending");

        // R2: disabled and reserved codes
        ivl_code = 4'd0;  bytes(20, "R2 code0 no request");
        ivl_code = 4'd11; bytes(20, "R2 code11 no request");
        ivl_code = 4'd15; bytes(5,  "R2 code15 no request");
        ivl_code = 4'd1;
        bytes(3, "R2 counter did not advance");
        byte_req("R2 full interval after disabled codes");

        // R1: code 10 = 2048 bytes
        ivl_code = 4'd10;
        step(0, 0, 1, 0, 0, 0, 0, "R4 clear before code10");
        bytes(2047, "R1 code10 before interval");
        byte_req("R1 code10 request on 2048th byte");
        ivl_code = 4'd1;

        // R3 / R9: inactive window holds the count
        step(0, 0, 1, 0, 0, 0, 0, "R4 clear before hold test");
        bytes(2, "R9 two bytes in window");
        target_mode = 1'b0;
        bytes(5, "R3 initiator mode no request");
        step(0, 1, 0, 0, 1, 0, 0, "R3 force ignored in initiator mode");
        proto_chk_off = 1'b1;
        target_mode = 1'b1;
        bus_phase = 3'b100;
        bytes(3, "R3 non-DT phase no request");
        bus_phase = 3'b000;
        bytes(1, "R9 count resumes");
        proto_chk_off = 1'b0;
        byte_req("R9 request after held count");

        // R4: clear mid-interval
        bytes(3, "R4 three bytes");
        step(0, 0, 1, 0, 1, 0, 0, "R4 clear mid interval");
        bytes(3, "R4 restart needs full interval");
        byte_req("R4 request after full interval");

        // R6: forced requests
        bytes(1, "R6 one byte");
        step(0, 1, 0, 1, 0, 0, 0, "R6 forced request");
        step(0, 1, 0, 0, 0, 0, 0, "R6 second force blocked");
        bytes(3, "R6 force restarted the count");
        byte_req("R6 auto request after force");
        step(0, 1, 0, 0, 0, 0, 0, "R6 force right after request blocked");
        bytes(1, "R6 byte re-arms");
        step(1, 1, 0, 1, 0, 0, 0, "R6 force with byte gives one request");
        bytes(3, "R6 count cleared by force");
        byte_req("R6 auto request after force with byte");

        // R7: phase-change protocol check
        bytes(1, "R7 data moved");
        bus_phase = 3'b001;
        step(0, 0, 0, 0, 1, 1, 0, "R7 phase change without request");
        step(0, 0, 0, 0, 1, 0, 0, "R7 error is one cycle");
        step(0, 1, 0, 1, 0, 0, 0, "R7 forced request before change");
        bus_phase = 3'b000;
        step(0, 0, 0, 0, 0, 0, 0, "R7 change after request is clean");
        bytes(1, "R7 data moved again");
        proto_chk_off = 1'b1;
        bus_phase = 3'b001;
        step(0, 0, 0, 0, 1, 0, 0, "R7 check disabled");
        proto_chk_off = 1'b0;
        bus_phase = 3'b100;
        step(0, 0, 0, 0, 1, 1, 0, "R7 leaving DT without request");
        bus_phase = 3'b000;
        step(0, 0, 0, 0, 1, 0, 0, "R7 entering DT is clean");

        // R8: CRC error reporting
        crc_mismatch = 1'b1;
        step(0, 0, 0, 0, 1, 0, 1, "R8 mismatch reported");
        crc_chk_off = 1'b1;
        step(0, 0, 0, 0, 1, 0, 0, "R8 mismatch suppressed");
        crc_mismatch = 1'b0;
        crc_chk_off = 1'b0;
        step(0, 0, 0, 0, 1, 0, 0, "R8 no mismatch");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule